// File: doc/BRIEF.md
# Reset Sequencer with Cause Flags

This block decides when a mixed-signal part leaves reset, when it runs normally and when it falls to its low-power sleep state. It collects reset requests from power-on, from under-voltage on the core and IO supply rails, from a watchdog expiry, from the externally pulled reset pad and from a wake event while asleep. It drives an open-drain reset pad low while an internal cause is active. After the cause clears, it keeps the pad low for a programmable stretch time.

Once the stretch ends, the pad is released and the sequencer waits until the pad reads high and both rails report good before it enters normal mode. A rail that stays low while the battery is good, for a programmable number of cycles, sends the part straight to sleep. A sticky status register records which causes have occurred. Software reads the flags and clears them with write-one-to-clear.

States are HOLD (an internal supply cause is active), STRETCH (the pad is held low while the counter runs), RELEASE (the pad is let go and the sequencer waits for the pad and the rails), NORMAL and SLEEP. The transitions are:
- HOLD to STRETCH when both rails are good.
- STRETCH to RELEASE when the count ends.
- RELEASE to NORMAL when the pad reads high.
- Any of STRETCH, RELEASE or NORMAL to HOLD on a rail fault.
- Any of STRETCH, RELEASE or NORMAL to STRETCH on a watchdog expiry.
- NORMAL to RELEASE when the pad is pulled low from outside.
- Any non-sleep state to SLEEP on a sustained fault.
- SLEEP to STRETCH on a wake request.

Top module: `rst_sequencer`

## Requirements
- R1: While `por_n` is low and right after it, the status register reads 6'b000001 and `rst_drive_low` is 1. The flag bits are: bit0 power-on, bit1 core low-voltage, bit2 IO low-voltage, bit3 watchdog, bit4 external pad, bit5 wake-from-sleep. `mode` reads 2'b00. The mode codes are 2'b00 reset, 2'b01 normal and 2'b10 sleep.
- R2: After an internal cause ends (power-on release, rails good again, watchdog pulse, wake pulse), `rst_drive_low` stays 1 for exactly STRETCH_CYC cycles and then goes to 0.
- R3: A watchdog expiry during the stretch restarts it, so the pad is held low for a full STRETCH_CYC cycles after that expiry.
- R4: The sequencer enters normal mode only when the synchronized pad reads high and `core_ok` and `io_ok` are both 1. A pad held low from outside keeps `mode` at reset.
- R5: The pad level passes through a two-flop synchronizer. A low on `rst_pad_in` first changes `mode` on the third rising edge after it appears.
- R6: A pad pulled low from outside during normal mode puts the sequencer in reset without driving `rst_drive_low`, and sets flag bit4.
- R7: When `core_ok` or `io_ok` is 0 with `batt_ok` at 1 for FAULT_CYC consecutive cycles, `mode` becomes sleep. A shorter fault, or any length of fault with `batt_ok` at 0, does not lead to sleep.
- R8: In sleep, `rst_drive_low` is 1 and rail, watchdog and pad inputs neither change the state nor set flags. A `wake_req` pulse sets flag bit5 and starts a stretch.
- R9: The flags are sticky. A write with `reg_wr` clears each bit where `reg_wdata` is 1, and a cause that arrives in the same cycle wins over the clear.
- R10: A watchdog expiry outside sleep sets flag bit3, a core fault sets bit1 and an IO fault sets bit2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| core_ok | input | 1 | Core rail above its threshold |
| io_ok | input | 1 | IO rail above its threshold |
| batt_ok | input | 1 | Battery supply high enough to run the fault timeout |
| wdog_expire | input | 1 | Watchdog expiry pulse |
| wake_req | input | 1 | Wake request pulse while asleep |
| rst_pad_in | input | 1 | Level read back from the reset pad (asynchronous) |
| rst_drive_low | output | 1 | Pull the open-drain reset pad low |
| mode | output | 2 | Operating mode: 00 reset, 01 normal, 10 sleep |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 6 | Write-one-to-clear mask |
| reg_rdata | output | 6 | Status flags |

## Verification
The assertions check on every cycle that:
- normal mode is entered only when the pad and both rails are good;
- sleep is entered only on a fault-timer expiry and is left only through a wake request into the stretch;
- a release always follows a full stretch count;
- the synchronizer shifts one stage per cycle and the fault counter stays in range;
- flags never fall without a matching clear and always clear when asked without a competing cause.

Only the bench scenarios can show the measured pad-low lengths, and that these lengths hold for every restart offset. The same holds for the sweep of fault durations around the timeout on both rails, for the three-edge pad latency, and for inputs being ignored during sleep.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
    typedef enum logic [2:0] {
        ST_HOLD    = 3'd0,
        ST_STRETCH = 3'd1,
        ST_RELEASE = 3'd2,
        ST_NORMAL  = 3'd3,
        ST_SLEEP   = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        MODE_RESET  = 2'b00,
        MODE_NORMAL = 2'b01,
        MODE_SLEEP  = 2'b10
    } sys_mode_t;

    localparam int FLAG_W = 6;
    localparam int F_POR  = 0;
    localparam int F_CORE = 1;
    localparam int F_IO   = 2;
    localparam int F_WDOG = 3;
    localparam int F_EXT  = 4;
    localparam int F_WAKE = 5;
    localparam logic [FLAG_W-1:0] FLAGS_AT_POR = 6'b000001;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d_async};
    end

    assign q_sync = sh_q[STAGES-1];

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage_chk
            // R5: each stage takes the previous stage's value one cycle later
            p_shift_r5: assert property (@(posedge clk) disable iff (!por_n)
                sh_q[g] == $past(sh_q[g-1]));
        end
    endgenerate
endmodule

// File: rtl/rstseq_fault_timer.sv
module rstseq_fault_timer #(
    parameter int FAULT_CYC = 64
) (
    input  logic clk,
    input  logic por_n,
    input  logic fault_cond,
    output logic fault_hit
);
    localparam int CW = (FAULT_CYC > 2) ? $clog2(FAULT_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(FAULT_CYC - 1);

    logic [CW-1:0] run_q;

    assign fault_hit = fault_cond && (run_q == CNT_LAST);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                   run_q <= '0;
        else if (!fault_cond || fault_hit) run_q <= '0;
        else                          run_q <= run_q + 1'b1;
    end

    // R7: the run counter never passes the timeout value
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!por_n)
        run_q <= CNT_LAST);
    // R7: a nonzero count means the fault was present on the previous edge
    p_cnt_needs_fault_r7: assert property (@(posedge clk) disable iff (!por_n)
        (run_q != '0) |-> $past(fault_cond));
endmodule

// File: rtl/rstseq_flags.sv
module rstseq_flags
    import rstseq_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic [FLAG_W-1:0] cause_set,
    input  logic              clr_wr,
    input  logic [FLAG_W-1:0] clr_mask,
    output logic [FLAG_W-1:0] flags
);
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] clr_eff;

    assign clr_eff = clr_wr ? clr_mask : '0;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) flags_q <= FLAGS_AT_POR;
        else        flags_q <= cause_set | (flags_q & ~clr_eff);
    end

    assign flags = flags_q;

    // R9: a flag only falls when a clear was written for it
    p_sticky_r9: assert property (@(posedge clk) disable iff (!por_n)
        ($past(flags_q) & ~flags_q & ~$past(clr_eff)) == '0);
    // R9: a clear with no competing cause leaves the bit at 0
    p_w1c_r9: assert property (@(posedge clk) disable iff (!por_n)
        (flags_q & $past(clr_eff & ~cause_set)) == '0);
    // R9: a cause always shows in the next cycle
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!por_n)
        (flags_q & $past(cause_set)) == $past(cause_set));
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
    import rstseq_pkg::*;
#(
    parameter int STRETCH_CYC = 16,
    parameter int FAULT_CYC   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        core_ok,
    input  logic        io_ok,
    input  logic        batt_ok,
    input  logic        wdog_expire,
    input  logic        wake_req,
    input  logic        rst_pad_in,
    output logic        rst_drive_low,
    output logic [1:0]  mode,
    input  logic        reg_wr,
    input  logic [5:0]  reg_wdata,
    output logic [5:0]  reg_rdata
);
    localparam int SW = (STRETCH_CYC > 2) ? $clog2(STRETCH_CYC) : 1;
    localparam logic [SW-1:0] STRETCH_LAST = SW'(STRETCH_CYC - 1);

    seq_state_t        state, nxt;
    logic [SW-1:0]     stretch_cnt;
    logic              stretch_load;
    logic              pin_sync;
    logic              rail_bad;
    logic              fault_cond;
    logic              fault_hit;
    logic [FLAG_W-1:0] cause_set;

    assign rail_bad = !core_ok || !io_ok;

    rstseq_sync #(.STAGES(SYNC_STAGES)) u_pad_sync (
        .clk     (clk),
        .por_n   (por_n),
        .d_async (rst_pad_in),
        .q_sync  (pin_sync)
    );

    assign fault_cond = rail_bad && batt_ok && (state != ST_SLEEP);

    rstseq_fault_timer #(.FAULT_CYC(FAULT_CYC)) u_fault (
        .clk        (clk),
        .por_n      (por_n),
        .fault_cond (fault_cond),
        .fault_hit  (fault_hit)
    );

    // Next-state decision
    always_comb begin
        nxt          = state;
        stretch_load = 1'b0;
        unique case (state)
            ST_HOLD: begin
                if (!rail_bad) begin
                    nxt          = ST_STRETCH;
                    stretch_load = 1'b1;
                end
            end
            ST_STRETCH: begin
                if (rail_bad) begin
                    nxt = ST_HOLD;
                end else if (wdog_expire) begin
                    stretch_load = 1'b1;
                end else if (stretch_cnt == STRETCH_LAST) begin
                    nxt = ST_RELEASE;
                end
            end
            ST_RELEASE: begin
                if (rail_bad) begin
                    nxt = ST_HOLD;
                end else if (wdog_expire) begin
                    nxt          = ST_STRETCH;
                    stretch_load = 1'b1;
                end else if (pin_sync) begin
                    nxt = ST_NORMAL;
                end
            end
            ST_NORMAL: begin
                if (rail_bad) begin
                    nxt = ST_HOLD;
                end else if (wdog_expire) begin
                    nxt          = ST_STRETCH;
                    stretch_load = 1'b1;
                end else if (!pin_sync) begin
                    nxt = ST_RELEASE;
                end
            end
            ST_SLEEP: begin
                if (wake_req) begin
                    nxt          = ST_STRETCH;
                    stretch_load = 1'b1;
                end
            end
            default: nxt = ST_HOLD;
        endcase
        if (fault_hit) begin
            nxt          = ST_SLEEP;
            stretch_load = 1'b0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= ST_STRETCH;
        else        state <= nxt;
    end

    // Stretch counter
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                 stretch_cnt <= '0;
        else if (stretch_load)      stretch_cnt <= '0;
        else if (state == ST_STRETCH) stretch_cnt <= stretch_cnt + 1'b1;
    end

    // Outputs decoded from the state
    always_comb begin
        unique case (state)
            ST_HOLD, ST_STRETCH: begin
                rst_drive_low = 1'b1;
                mode          = MODE_RESET;
            end
            ST_RELEASE: begin
                rst_drive_low = 1'b0;
                mode          = MODE_RESET;
            end
            ST_NORMAL: begin
                rst_drive_low = 1'b0;
                mode          = MODE_NORMAL;
            end
            ST_SLEEP: begin
                rst_drive_low = 1'b1;
                mode          = MODE_SLEEP;
            end
            default: begin
                rst_drive_low = 1'b1;
                mode          = MODE_RESET;
            end
        endcase
    end

    // Cause detection for the status flags
    always_comb begin
        cause_set         = '0;
        cause_set[F_CORE] = !core_ok && (state != ST_SLEEP);
        cause_set[F_IO]   = !io_ok && (state != ST_SLEEP);
        cause_set[F_WDOG] = wdog_expire && (state != ST_SLEEP);
        cause_set[F_EXT]  = (state == ST_NORMAL) && !pin_sync;
        cause_set[F_WAKE] = (state == ST_SLEEP) && wake_req;
    end

    rstseq_flags u_flags (
        .clk       (clk),
        .por_n     (por_n),
        .cause_set (cause_set),
        .clr_wr    (reg_wr),
        .clr_mask  (reg_wdata),
        .flags     (reg_rdata)
    );

    // R4: normal mode is only entered with the pad high and both rails good
    p_normal_entry_r4: assert property (@(posedge clk) disable iff (!por_n)
        $rose(state == ST_NORMAL) |-> $past(pin_sync && core_ok && io_ok));
    // R2: release follows a completed stretch count
    p_stretch_len_r2: assert property (@(posedge clk) disable iff (!por_n)
        ((state == ST_RELEASE) && $past(state == ST_STRETCH))
            |-> ($past(stretch_cnt) == STRETCH_LAST));
    // R7: sleep is only entered on a fault-timer expiry
    p_sleep_entry_r7: assert property (@(posedge clk) disable iff (!por_n)
        $rose(state == ST_SLEEP) |-> $past(fault_hit));
    // R8: sleep is left only by a wake request, into the stretch
    p_wake_exit_r8: assert property (@(posedge clk) disable iff (!por_n)
        $fell(state == ST_SLEEP) |-> ($past(wake_req) && state == ST_STRETCH));
endmodule

// File: tb/rst_sequencer_tb.sv
module rst_sequencer_tb;
    localparam int S = 4;
    localparam int F = 6;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       core_ok = 1'b1, io_ok = 1'b1, batt_ok = 1'b1;
    logic       wdog_expire = 1'b0, wake_req = 1'b0;
    logic       ext_low = 1'b0;
    logic       reg_wr = 1'b0;
    logic [5:0] reg_wdata = '0;
    logic       rst_drive_low;
    logic [1:0] mode;
    logic [5:0] reg_rdata;
    logic       rst_pad;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Open-drain pad: low if the block or the outside world pulls it
    assign rst_pad = !(ext_low || rst_drive_low);

    always #2 clk = ~clk;

    rst_sequencer #(.STRETCH_CYC(S), .FAULT_CYC(F)) u_dut (
        .clk(clk), .por_n(por_n), .core_ok(core_ok), .io_ok(io_ok),
        .batt_ok(batt_ok), .wdog_expire(wdog_expire), .wake_req(wake_req),
        .rst_pad_in(rst_pad), .rst_drive_low(rst_drive_low), .mode(mode),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count cycles the pad stays driven, starting at the current sample
    task automatic count_low(output int n);
        n = 0;
        while (rst_drive_low && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_mode(input logic [1:0] tgt, input int lim, output int ok);
        ok = 0;
        for (int i = 0; i < lim; i++) begin
            if (mode == tgt) begin
                ok = 1;
                break;
            end
            @(negedge clk);
        end
        if (mode == tgt) ok = 1;
    endtask

    task automatic clr_flags(input logic [5:0] m);
        reg_wr = 1'b1;
        reg_wdata = m;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic pulse_wdog();
        wdog_expire = 1'b1;
        @(negedge clk);
        wdog_expire = 1'b0;
    endtask

    task automatic pulse_wake();
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
    endtask

    initial begin
        int n;
        int ok;
        repeat (3) @(negedge clk);
        chk("R1 flags at power-on", reg_rdata, 6'b000001);
        chk("R1 pad driven in power-on", rst_drive_low, 1);
        chk("R1 mode at power-on", mode, 0);

        por_n = 1'b1;
        count_low(n);
        chk("R2 stretch after power-on", n, S);
        wait_mode(2'b01, 10, ok);
        chk("R4 normal after power-on", ok, 1);
        chk("R1 power-on flag kept", reg_rdata, 6'b000001);
        clr_flags(6'h3F);
        chk("R9 write-one clears all", reg_rdata, 0);

        // Watchdog
        pulse_wdog();
        count_low(n);
        chk("R2 stretch after watchdog", n, S);
        chk("R10 watchdog flag", reg_rdata, 6'b001000);
        wait_mode(2'b01, 10, ok);
        chk("R4 normal after watchdog", ok, 1);
        clr_flags(6'h01);
        chk("R9 clear of other bit leaves watchdog flag", reg_rdata, 6'b001000);
        clr_flags(6'h08);

        // Core and IO rail faults
        for (int r = 0; r < 2; r++) begin
            if (r == 0) core_ok = 1'b0; else io_ok = 1'b0;
            @(negedge clk);
            chk("R2 pad driven during rail fault", rst_drive_low, 1);
            chk("R10 rail flag", reg_rdata, (r == 0) ? 6'b000010 : 6'b000100);
            core_ok = 1'b1;
            io_ok = 1'b1;
            @(negedge clk);
            count_low(n);
            chk("R2 stretch after rail fault", n, S);
            wait_mode(2'b01, 10, ok);
            chk("R4 normal after rail fault", ok, 1);
            clr_flags(6'h3F);
        end

        // Restart sweep
        for (int k = 0; k < S; k++) begin
            pulse_wdog();
            repeat (k) @(negedge clk);
            pulse_wdog();
            count_low(n);
            chk("R3 stretch restarted by watchdog", n, S);
            wait_mode(2'b01, 10, ok);
            chk("R3 normal after restart", ok, 1);
        end
        clr_flags(6'h3F);

        // Pad held low from outside keeps the part in reset
        ext_low = 1'b1;
        pulse_wdog();
        count_low(n);
        chk("R2 stretch with pad held", n, S);
        repeat (6) @(negedge clk);
        chk("R4 stays in reset while pad low", mode, 0);
        ext_low = 1'b0;
        wait_mode(2'b01, 5, ok);
        chk("R4 normal once pad high", ok, 1);
        clr_flags(6'h3F);

        // External pad reset and synchronizer latency
        ext_low = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5 no reaction after two edges", mode, 1);
        @(negedge clk);
        chk("R5 reset on third edge", mode, 0);
        chk("R6 pad not driven for external reset", rst_drive_low, 0);
        chk("R6 external flag", reg_rdata, 6'b010000);
        ext_low = 1'b0;
        wait_mode(2'b01, 5, ok);
        chk("R6 normal after external reset", ok, 1);
        clr_flags(6'h3F);

        // Fault duration sweep on both rails
        for (int r = 0; r < 2; r++) begin
            for (int d = 1; d <= F + 1; d++) begin
                if (r == 0) core_ok = 1'b0; else io_ok = 1'b0;
                repeat (d) @(negedge clk);
                core_ok = 1'b1;
                io_ok = 1'b1;
                @(negedge clk);
                chk("R7 sleep only after full timeout", mode, (d >= F) ? 2 : 0);
                if (d >= F) begin
                    chk("R8 pad driven in sleep", rst_drive_low, 1);
                    pulse_wake();
                    count_low(n);
                    chk("R8 stretch after wake", n, S);
                    chk("R8 wake flag", reg_rdata[5], 1);
                end
                wait_mode(2'b01, 12, ok);
                chk("R7 back to normal", ok, 1);
                clr_flags(6'h3F);
            end
        end

        // No sleep without battery
        batt_ok = 1'b0;
        core_ok = 1'b0;
        repeat (3 * F) @(negedge clk);
        core_ok = 1'b1;
        @(negedge clk);
        chk("R7 no sleep with battery low", mode, 0);
        batt_ok = 1'b1;
        wait_mode(2'b01, 12, ok);
        chk("R7 normal after battery-low fault", ok, 1);

        // Inputs ignored in sleep
        core_ok = 1'b0;
        repeat (F) @(negedge clk);
        core_ok = 1'b1;
        @(negedge clk);
        clr_flags(6'h3F);
        core_ok = 1'b0;
        io_ok = 1'b0;
        wdog_expire = 1'b1;
        ext_low = 1'b1;
        repeat (3) @(negedge clk);
        core_ok = 1'b1;
        io_ok = 1'b1;
        wdog_expire = 1'b0;
        ext_low = 1'b0;
        @(negedge clk);
        chk("R8 sleep kept despite inputs", mode, 2);
        chk("R8 no flags set in sleep", reg_rdata, 0);
        pulse_wake();
        chk("R8 wake flag alone", reg_rdata, 6'b100000);
        wait_mode(2'b01, 12, ok);
        chk("R8 normal after wake", ok, 1);
        clr_flags(6'h3F);

        // Cause wins over a clear in the same cycle
        wdog_expire = 1'b1;
        reg_wr = 1'b1;
        reg_wdata = 6'b001000;
        @(negedge clk);
        wdog_expire = 1'b0;
        reg_wr = 1'b0;
        reg_wdata = '0;
        chk("R9 set wins over clear", reg_rdata, 6'b001000);
        wait_mode(2'b01, 12, ok);
        chk("R9 normal after watchdog", ok, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule